// File: doc/BRIEF.md
# MDIO Port Router with Presence Strap

The block sits between a management-bus master and two possible PHY attachments: a PHY inside the chip and an external PHY port reached through pins. One select bit in a small configuration register decides which attachment sees the master's MDC clock and MDIO data. The attachment that is not selected is held at fixed, quiet levels. The internal side is driven low. On the external side the MDIO pad is released and MDC is held low.

The external MDIO pin also acts as a presence strap. On the first clock after hard reset is released, the block samples the level on the pin while its own pad driver is held off. It holds that level as a read-only detect bit until the next hard reset. The register also has an external-PHY enable bit. That bit is plain storage for other logic and has no effect on routing.

A change of the select bit never cuts a management transaction in two. While the master reports busy, a requested change waits and is applied once busy drops.

Top module: `mdio_port_router`

## Requirements
- R1: After hard reset, the select bit (bit 4) and the enable bit (bit 2) read 0, and the internal PHY is the routed port.
- R2: While bit 4 reads 0, the master's MDC, MDIO data and MDIO output enable pass to the internal side. External MDC is 0, external MDIO output enable is 0 and external MDIO data out is 0.
- R3: While bit 4 reads 1, the master's MDC, MDIO data and MDIO output enable pass to the external pins. Internal MDC is 0, internal MDIO data out is 0 and internal MDIO output enable is 1, so the internal line is driven low.
- R4: The master's MDIO input always equals the MDIO input of the port that bit 4 currently selects.
- R5: When busy is low, a register write that changes bit 4 is applied at the clock edge that captures the write. It is visible in the readback and in the routing from that edge onward, and not before it.
- R6: While busy is high, the applied select holds. The value written last is applied at the first clock edge at which busy is sampled low.
- R7: Bit 2 (external enable) is read/write and does not change routing.
- R8: Bit 3 (detect) reads the level of the external MDIO pin sampled at the first clock after hard reset is released. The external MDIO output enable is 0 until that sample is taken. The bit then holds against pin changes and register writes until the next hard reset.
- R9: All register bits other than 2, 3 and 4 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| reg_we_i | input | 1 | Configuration register write strobe |
| reg_wdata_i | input | CFG_W | Configuration register write data |
| reg_rdata_o | output | CFG_W | Configuration register read data |
| mgmt_mdc_i | input | 1 | MDC from the management master |
| mgmt_mdo_i | input | 1 | MDIO data out from the master |
| mgmt_mdo_en_i | input | 1 | MDIO output enable from the master |
| mgmt_busy_i | input | 1 | Master transaction in progress |
| mgmt_mdi_o | output | 1 | MDIO data in to the master |
| int_mdc_o | output | 1 | MDC to the internal PHY |
| int_mdio_o | output | 1 | MDIO data to the internal PHY |
| int_mdio_oe_o | output | 1 | Internal MDIO drive enable |
| int_mdio_i | input | 1 | MDIO data from the internal PHY |
| ext_mdc_o | output | 1 | External MDC pin |
| ext_mdio_o | output | 1 | External MDIO pad data out |
| ext_mdio_oe_o | output | 1 | External MDIO pad output enable |
| ext_mdio_i | input | 1 | External MDIO pad input |

## Verification
The hardest situations to reach are a select change that meets a busy transaction and the strap sample window. In the first, several writes arrive while busy is high, and the bench checks that the routing stays put and that the last write lands one edge after busy drops. For the strap, the bench applies hard reset twice with opposite pin levels and checks the pad enable in the cycle between reset release and the first edge. It then toggles the pin and writes bit 3 afterwards to show that the latched value holds. Routing is swept over every combination of master outputs and both PHY inputs in each select state.

// File: rtl/mdio_rt_pkg.sv
package mdio_rt_pkg;
  typedef enum logic {
    PORT_INT = 1'b0,
    PORT_EXT = 1'b1
  } port_e;

  typedef struct packed {
    logic mdc;
    logic mdo;
    logic oe;
  } mdio_drv_t;
endpackage

// File: rtl/mdio_rt_strap.sv
module mdio_rt_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic det_o,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_o  <= 1'b0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      det_o  <= pin_i;
      done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_rt_cfg.sv
module mdio_rt_cfg
  import mdio_rt_pkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int SEL_BIT = 4,
  parameter int DET_BIT = 3,
  parameter int EN_BIT  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             busy_i,
  input  logic             det_i,
  output port_e            sel_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic  sel_req_q, sel_next, ext_en_q;
  port_e sel_q;

  // last written select wins; applied only while master idle
  assign sel_next = we_i ? wdata_i[SEL_BIT] : sel_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_req_q <= 1'b0;
      sel_q     <= PORT_INT;
      ext_en_q  <= 1'b0;
    end else begin
      sel_req_q <= sel_next;
      if (!busy_i) sel_q <= port_e'(sel_next);
      if (we_i) ext_en_q <= wdata_i[EN_BIT];
    end
  end

  assign sel_o = sel_q;

  for (genvar b = 0; b < CFG_W; b++) begin : g_rd
    if (b == SEL_BIT) begin : g_sel
      assign rdata_o[b] = sel_q;
    end else if (b == DET_BIT) begin : g_det
      assign rdata_o[b] = det_i;
    end else if (b == EN_BIT) begin : g_en
      assign rdata_o[b] = ext_en_q;
    end else begin : g_zero
      assign rdata_o[b] = 1'b0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/mdio_rt_mux.sv
module mdio_rt_mux
  import mdio_rt_pkg::*;
(
  input  port_e     sel_i,
  input  logic      strap_done_i,
  input  mdio_drv_t mst_i,
  output logic      mst_mdi_o,
  output mdio_drv_t int_o,
  input  logic      int_mdi_i,
  output mdio_drv_t ext_o,
  input  logic      ext_mdi_i
);
  localparam mdio_drv_t INT_PARK = '{mdc: 1'b0, mdo: 1'b0, oe: 1'b1};
  localparam mdio_drv_t EXT_PARK = '{mdc: 1'b0, mdo: 1'b0, oe: 1'b0};

  mdio_drv_t ext_raw;

  always_comb begin
    if (sel_i == PORT_EXT) begin
      int_o     = INT_PARK;
      ext_raw   = mst_i;
      mst_mdi_o = ext_mdi_i;
    end else begin
      int_o     = mst_i;
      ext_raw   = EXT_PARK;
      mst_mdi_o = int_mdi_i;
    end
    ext_o = ext_raw;
    // pad stays released until the strap is sampled
    if (!strap_done_i) ext_o.oe = 1'b0;
  end
endmodule

// File: rtl/mdio_port_router.sv
module mdio_port_router
  import mdio_rt_pkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int SEL_BIT = 4,
  parameter int DET_BIT = 3,
  parameter int EN_BIT  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [CFG_W-1:0] reg_wdata_i,
  output logic [CFG_W-1:0] reg_rdata_o,
  input  logic             mgmt_mdc_i,
  input  logic             mgmt_mdo_i,
  input  logic             mgmt_mdo_en_i,
  input  logic             mgmt_busy_i,
  output logic             mgmt_mdi_o,
  output logic             int_mdc_o,
  output logic             int_mdio_o,
  output logic             int_mdio_oe_o,
  input  logic             int_mdio_i,
  output logic             ext_mdc_o,
  output logic             ext_mdio_o,
  output logic             ext_mdio_oe_o,
  input  logic             ext_mdio_i
);
  port_e     sel;
  logic      det, strap_done;
  mdio_drv_t mst_drv, int_drv, ext_drv;

  mdio_rt_strap i_strap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_mdio_i),
    .det_o (det),
    .done_o(strap_done)
  );

  mdio_rt_cfg #(
    .CFG_W  (CFG_W),
    .SEL_BIT(SEL_BIT),
    .DET_BIT(DET_BIT),
    .EN_BIT (EN_BIT)
  ) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .busy_i (mgmt_busy_i),
    .det_i  (det),
    .sel_o  (sel),
    .rdata_o(reg_rdata_o)
  );

  assign mst_drv = '{mdc: mgmt_mdc_i, mdo: mgmt_mdo_i, oe: mgmt_mdo_en_i};

  mdio_rt_mux i_mux (
    .sel_i       (sel),
    .strap_done_i(strap_done),
    .mst_i       (mst_drv),
    .mst_mdi_o   (mgmt_mdi_o),
    .int_o       (int_drv),
    .int_mdi_i   (int_mdio_i),
    .ext_o       (ext_drv),
    .ext_mdi_i   (ext_mdio_i)
  );

  assign int_mdc_o     = int_drv.mdc;
  assign int_mdio_o    = int_drv.mdo;
  assign int_mdio_oe_o = int_drv.oe;
  assign ext_mdc_o     = ext_drv.mdc;
  assign ext_mdio_o    = ext_drv.mdo;
  assign ext_mdio_oe_o = ext_drv.oe;
endmodule

// File: rtl/mdio_rt_checker.sv
module mdio_rt_checker #(
  parameter int CFG_W   = 8,
  parameter int SEL_BIT = 4,
  parameter int DET_BIT = 3,
  parameter int EN_BIT  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CFG_W-1:0] reg_rdata_o,
  input logic             mgmt_busy_i,
  input logic             mgmt_mdi_o,
  input logic             int_mdc_o,
  input logic             int_mdio_o,
  input logic             int_mdio_oe_o,
  input logic             int_mdio_i,
  input logic             ext_mdc_o,
  input logic             ext_mdio_oe_o,
  input logic             ext_mdio_i
);
  localparam logic [CFG_W-1:0] USED =
    (CFG_W'(1) << SEL_BIT) | (CFG_W'(1) << DET_BIT) | (CFG_W'(1) << EN_BIT);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_ext_park_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[SEL_BIT] |-> (!ext_mdc_o && !ext_mdio_oe_o));

  p_int_park_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[SEL_BIT] |-> (!int_mdc_o && !int_mdio_o && int_mdio_oe_o));

  p_mdi_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_mdi_o == (reg_rdata_o[SEL_BIT] ? ext_mdio_i : int_mdio_i));

  p_hold_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_busy_i |=> $stable(reg_rdata_o[SEL_BIT]));

  p_strap_pad_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !ext_mdio_oe_o);

  p_strap_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |=> reg_rdata_o[DET_BIT] == $past(ext_mdio_i));

  p_strap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> $stable(reg_rdata_o[DET_BIT]));

  p_spare_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~USED) == '0);
endmodule

bind mdio_port_router mdio_rt_checker #(
  .CFG_W  (CFG_W),
  .SEL_BIT(SEL_BIT),
  .DET_BIT(DET_BIT),
  .EN_BIT (EN_BIT)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_rdata_o  (reg_rdata_o),
  .mgmt_busy_i  (mgmt_busy_i),
  .mgmt_mdi_o   (mgmt_mdi_o),
  .int_mdc_o    (int_mdc_o),
  .int_mdio_o   (int_mdio_o),
  .int_mdio_oe_o(int_mdio_oe_o),
  .int_mdio_i   (int_mdio_i),
  .ext_mdc_o    (ext_mdc_o),
  .ext_mdio_oe_o(ext_mdio_oe_o),
  .ext_mdio_i   (ext_mdio_i)
);

// File: tb/test_mdio_port_router.sv
`timescale 1ns/1ps
module test_mdio_port_router;
  localparam int CFG_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [CFG_W-1:0] reg_wdata_i = '0, reg_rdata_o;
  logic mgmt_mdc_i = 0, mgmt_mdo_i = 0, mgmt_mdo_en_i = 0, mgmt_busy_i = 0, mgmt_mdi_o;
  logic int_mdc_o, int_mdio_o, int_mdio_oe_o, int_mdio_i = 0;
  logic ext_mdc_o, ext_mdio_o, ext_mdio_oe_o, ext_mdio_i = 0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  mdio_port_router i_mdio_port_router (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hard_reset(input logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0;
    ext_mdio_i = strap;
    mgmt_mdo_en_i = 1'b1;
    #1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #0.5;
    check("R8 pad off before strap sample", {7'd0, ext_mdio_oe_o}, 8'h00);
    @(negedge clk_i);
    check("R1/R8 reset readback", reg_rdata_o, {4'd0, strap, 3'd0});
    mgmt_mdo_en_i = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // drive all 32 combos of master outputs and PHY inputs, compare routing
  task automatic sweep(input logic sel, input string tag);
    for (int v = 0; v < 32; v++) begin
      logic [6:0] exp, act;
      mgmt_mdc_i = v[0]; mgmt_mdo_i = v[1]; mgmt_mdo_en_i = v[2];
      int_mdio_i = v[3]; ext_mdio_i = v[4];
      #0.5;
      if (!sel) exp = {v[3], v[0], v[1], v[2], 3'b000};
      else      exp = {v[4], 3'b001, v[0], v[1], v[2]};
      act = {mgmt_mdi_o, int_mdc_o, int_mdio_o, int_mdio_oe_o,
             ext_mdc_o, ext_mdio_o, ext_mdio_oe_o};
      check(tag, {1'b0, act}, {1'b0, exp});
    end
    mgmt_mdc_i = 0; mgmt_mdo_i = 0; mgmt_mdo_en_i = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    hard_reset(1'b1);                                // R1, R8
    sweep(1'b0, "R2/R4 internal routing");

    // R5: applied at capture edge, not earlier
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = 8'h10;
    #0.5;
    check("R5 not before edge", reg_rdata_o, 8'h08);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    check("R5 applied after edge", reg_rdata_o, 8'h18);
    sweep(1'b1, "R3/R4 external routing");

    // R9: spare bits ignored, R8: detect not writable
    reg_write(8'hFF);
    check("R9 spare bits / R7 enable / R8 det hold", reg_rdata_o, 8'h1C);
    reg_write(8'h04);
    check("R7 enable without select", reg_rdata_o, 8'h0C);
    sweep(1'b0, "R7 enable no routing effect");
    reg_write(8'h00);
    check("R7 enable clears", reg_rdata_o, 8'h08);

    // R6: deferred while busy
    @(negedge clk_i); mgmt_busy_i = 1'b1;
    reg_write(8'h10);
    mgmt_mdc_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R6 held while busy", {6'd0, reg_rdata_o[4], ext_mdc_o}, 8'h00);
    end
    mgmt_mdc_i = 1'b0;
    mgmt_busy_i = 1'b0;
    #0.5;
    check("R6 still held before edge", {7'd0, reg_rdata_o[4]}, 8'h00);
    @(negedge clk_i);
    check("R6 applied after busy drop", reg_rdata_o, 8'h18);

    mgmt_busy_i = 1'b1;
    reg_write(8'h00);
    reg_write(8'h10);
    @(negedge clk_i);
    check("R6 two writes, still held", {7'd0, reg_rdata_o[4]}, 8'h01);
    mgmt_busy_i = 1'b0;
    @(negedge clk_i);
    check("R6 last write wins (1)", {7'd0, reg_rdata_o[4]}, 8'h01);

    mgmt_busy_i = 1'b1;
    reg_write(8'h00);
    @(negedge clk_i);
    check("R6 deselect held", {7'd0, reg_rdata_o[4]}, 8'h01);
    mgmt_busy_i = 1'b0;
    @(negedge clk_i);
    check("R6 deselect applied", reg_rdata_o, 8'h08);

    // R8: pin toggles after sample do not move detect
    for (int k = 0; k < 4; k++) begin
      ext_mdio_i = k[0];
      @(negedge clk_i);
      check("R8 detect holds on pin toggle", reg_rdata_o, 8'h08);
    end

    hard_reset(1'b0);                                // R1, R8 low strap
    ext_mdio_i = 1'b1;
    @(negedge clk_i);
    check("R8 low strap holds", reg_rdata_o, 8'h00);
    reg_write(8'h10);
    sweep(1'b1, "R3/R4 after second reset");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule